// File: doc/BRIEF.md
# Supply Monitor Debounce Filter

This block cleans up three slow supply-comparator levels before they become status bits. Each comparator output is asynchronous to the logic, so it is first brought into the low-speed real-time clock domain through a short flop chain. A filter for each monitor then lets its flag follow the input only after the input has disagreed with the flag for a programmed number of consecutive samples. One 8-bit debounce setting is shared by all three monitors. A setting of zero removes the filtering. A setting of N asks for N+1 agreeing samples, so the longest filter is 256 samples.

The three monitors are the core supply alarm (the input is high when the core supply is under its selected threshold), the external DC input drop detector (high when that input has dropped), and the analog supply low-voltage detector (high when the analog rail is under 2.5 V). The core supply alarm has a check-mode control. In the off mode its detector is powered down. In the periodic mode its filter takes one sample every `VDD_CHECK_CYCLES` clocks, which models the fixed 30 µs check interval. The other two monitors each have a power-down control, and they sample on every clock. All interfaces are plain level signals. No data flows through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `supply_deb_filter`

## Requirements
- R1: With debounce setting N (1..255), a flag changes only after N+1 consecutive synchronized samples differ from it. A raw input change set up before clock edge k shows on the flag after edge k+2+N. For N=255 that is 256 samples.
- R2: With debounce setting 0, a flag follows its raw input after edge k+2. This is the two synchronizer flops and no extra delay.
- R3: A flag falling back to 0 uses the same filtering and latency as a rising flag.
- R4: A run of differing samples shorter than N+1 leaves the flag unchanged. Any sample that agrees with the flag restarts the count.
- R5: A change of the debounce setting clears every channel's count and leaves the flags unchanged. Counting starts again against the new setting.
- R6: While a monitor's detector is powered down, its flag reads 0 from the next clock edge. After power-up the flag needs a full N+1 samples to assert.
- R7: When the core supply check mode is 0 (off), status bit 0 is 0. When the mode is 1 (periodic), that channel samples only once every `VDD_CHECK_CYCLES` clocks. With N=1 and a period of 4, the flag is still 0 after edge k+5 and is 1 after edge k+10.
- R8: Status bit 0 is the core supply alarm, bit 1 is the DC input drop flag, and bit 2 is the analog supply low flag. All three bits are 0 after reset.
- R9: The channels filter independently. Each flag's timing depends only on its own input history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rtc | input | 1 | Low-speed real-time clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vdd_alarm_raw | input | 1 | Core supply under-threshold comparator, asynchronous |
| vdcin_drop_raw | input | 1 | DC input drop comparator, asynchronous |
| avcc_low_raw | input | 1 | Analog supply low comparator, asynchronous |
| deb_sel | input | 8 | Shared debounce setting: 0 is bypass, N means N+1 samples |
| vdd_chk_mode | input | 1 | Core supply check mode: 0 is off (detector down), 1 is periodic |
| vdcin_det_en | input | 1 | DC input drop detector power enable |
| avcc_det_en | input | 1 | Analog supply detector power enable |
| status_o | output | 3 | Debounced flags {analog low, DC drop, core alarm} |

## Verification
The hardest case to reach from the ports is a debounce-setting change that arrives partway through a count. It is only visible as a delay, because the flag then asserts later than it would have with the old partial count carried over. The stimulus starts a deassertion with a setting of 5. After exactly four samples it raises the setting to 6. It then checks that the flag holds through edge k+11 and falls at edge k+12, where carrying the count over would have let it fall at k+8. Two more cases pin down the edges of the filter: a pulse one sample too short and a pulse of exactly N+1 samples. The periodic core supply channel is checked with bounds that hold for any phase of its sample tick.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
  localparam int NUM_CH   = 3;
  localparam int CH_VDD   = 0;
  localparam int CH_VDCIN = 1;
  localparam int CH_AVCC  = 2;
endpackage

// File: rtl/sdf_sync.sv
module sdf_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/sdf_tick.sv
module sdf_tick #(
  parameter int PERIOD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick_o
);
  localparam int W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);

  logic [W-1:0] cnt_q;

  assign tick_o = en && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!en)    cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + W'(1);
  end

  // R7: periodic sampling never fires on back-to-back clocks
  p_tick_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (!tick_o || PERIOD == 1));

  // R7: no sample tick while the check is off
  p_tick_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !tick_o);
endmodule

// File: rtl/sdf_chan.sv
module sdf_chan #(
  parameter int SEL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic             sample_en,
  input  logic             pwr_en,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             flag_o
);
  logic             flag_q;
  logic [SEL_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!pwr_en) begin
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (sample_en) begin
      if (din == flag_q) begin
        cnt_q <= '0;
      end else if (cnt_q == sel) begin
        flag_q <= din;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + SEL_W'(1);
      end
    end
  end

  assign flag_o = flag_q;

  // R6: a powered-down detector reads 0 from the next edge
  p_pwrdn_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |=> !flag_q);

  // R4: a short run of differing samples leaves the flag alone
  p_hold_short_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_en && !restart && sel != '0 && cnt_q != sel) |=> $stable(flag_q));

  // R2: bypass passes the synchronized input on the next sample
  p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_en && !restart && sample_en && sel == '0) |=> (flag_q == $past(din)));

  // R5: a setting change clears the count and keeps the flag
  p_restart_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && pwr_en) |=> (cnt_q == '0 && $stable(flag_q)));

  // R1: the count never passes the selected limit
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |-> (cnt_q <= sel));
endmodule

// File: rtl/supply_deb_filter.sv
module supply_deb_filter
  import sdf_pkg::*;
#(
  parameter int SEL_W            = 8,
  parameter int SYNC_STAGES      = 2,
  parameter int VDD_CHECK_CYCLES = 4
) (
  input  logic             clk_rtc,
  input  logic             rst_n,
  input  logic             vdd_alarm_raw,
  input  logic             vdcin_drop_raw,
  input  logic             avcc_low_raw,
  input  logic [SEL_W-1:0] deb_sel,
  input  logic             vdd_chk_mode,
  input  logic             vdcin_det_en,
  input  logic             avcc_det_en,
  output logic [2:0]       status_o
);
  logic [NUM_CH-1:0] raw_vec;
  logic [NUM_CH-1:0] sync_vec;
  logic [NUM_CH-1:0] samp_vec;
  logic [NUM_CH-1:0] pwr_vec;
  logic [NUM_CH-1:0] flag_vec;
  logic [SEL_W-1:0]  sel_q;
  logic              sel_restart;
  logic              vdd_tick;

  assign raw_vec[CH_VDD]   = vdd_alarm_raw;
  assign raw_vec[CH_VDCIN] = vdcin_drop_raw;
  assign raw_vec[CH_AVCC]  = avcc_low_raw;

  assign pwr_vec[CH_VDD]   = vdd_chk_mode;
  assign pwr_vec[CH_VDCIN] = vdcin_det_en;
  assign pwr_vec[CH_AVCC]  = avcc_det_en;

  assign samp_vec[CH_VDD]   = vdd_tick;
  assign samp_vec[CH_VDCIN] = 1'b1;
  assign samp_vec[CH_AVCC]  = 1'b1;

  sdf_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk_rtc),
    .rst_n   (rst_n),
    .async_i (raw_vec),
    .sync_o  (sync_vec)
  );

  sdf_tick #(.PERIOD(VDD_CHECK_CYCLES)) u_vdd_tick (
    .clk    (clk_rtc),
    .rst_n  (rst_n),
    .en     (vdd_chk_mode),
    .tick_o (vdd_tick)
  );

  always_ff @(posedge clk_rtc or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= deb_sel;
  end

  assign sel_restart = (deb_sel != sel_q);

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      sdf_chan #(.SEL_W(SEL_W)) u_chan (
        .clk       (clk_rtc),
        .rst_n     (rst_n),
        .din       (sync_vec[c]),
        .sample_en (samp_vec[c]),
        .pwr_en    (pwr_vec[c]),
        .restart   (sel_restart),
        .sel       (deb_sel),
        .flag_o    (flag_vec[c])
      );
    end
  endgenerate

  assign status_o = flag_vec;

  // R7: check mode off keeps the core supply flag low
  p_nocheck_zero_r7: assert property (@(posedge clk_rtc) disable iff (!rst_n)
    !vdd_chk_mode |=> !status_o[CH_VDD]);

  // R8: detectors powered down give a clear status word
  p_all_off_r8: assert property (@(posedge clk_rtc) disable iff (!rst_n)
    (!vdd_chk_mode && !vdcin_det_en && !avcc_det_en) |=> (status_o == 3'b000));
endmodule

// File: tb/supply_deb_filter_tb.sv
module supply_deb_filter_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [2:0] exp;
    string      tag;
  } item_t;

  logic       clk_rtc = 1'b0;
  logic       rst_n = 1'b0;
  logic       vdd_alarm_raw = 1'b0;
  logic       vdcin_drop_raw = 1'b0;
  logic       avcc_low_raw = 1'b0;
  logic [7:0] deb_sel = 8'd0;
  logic       vdd_chk_mode = 1'b0;
  logic       vdcin_det_en = 1'b1;
  logic       avcc_det_en = 1'b1;
  logic [2:0] status_o;

  item_t q[$];
  int    n_tests = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  always #(CLK_PERIOD/2) clk_rtc = ~clk_rtc;

  supply_deb_filter u_dut (
    .clk_rtc        (clk_rtc),
    .rst_n          (rst_n),
    .vdd_alarm_raw  (vdd_alarm_raw),
    .vdcin_drop_raw (vdcin_drop_raw),
    .avcc_low_raw   (avcc_low_raw),
    .deb_sel        (deb_sel),
    .vdd_chk_mode   (vdd_chk_mode),
    .vdcin_det_en   (vdcin_det_en),
    .avcc_det_en    (avcc_det_en),
    .status_o       (status_o)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk_rtc);
  endtask

  task automatic expect_now(input logic [2:0] e, input string tag);
    item_t it;
    it.exp = e;
    it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: compares the status word just after each falling edge
  initial begin
    forever begin
      @(negedge clk_rtc);
      #1;
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        n_tests++;
        if (status_o !== it.exp) begin
          n_fail++;
          $display("FAIL %s: status actual %b expected %b", it.tag, status_o, it.exp);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    expect_now(3'b000, "R8 reset state");

    // R2 bypass
    vdcin_drop_raw = 1'b1;
    step(2); expect_now(3'b000, "R2 before sync delay");
    step(1); expect_now(3'b010, "R2 bypass rise");
    vdcin_drop_raw = 1'b0;
    step(3); expect_now(3'b000, "R2 bypass fall");

    // R1 / R3 with setting 3
    deb_sel = 8'd3; step(3);
    vdcin_drop_raw = 1'b1;
    step(5); expect_now(3'b000, "R1 one sample short");
    step(1); expect_now(3'b010, "R1 rise after N+1");
    vdcin_drop_raw = 1'b0;
    step(5); expect_now(3'b010, "R3 fall one short");
    step(1); expect_now(3'b000, "R3 fall after N+1");

    // R4 pulse too short
    avcc_low_raw = 1'b1; step(3); avcc_low_raw = 1'b0;
    expect_now(3'b000, "R4 short pulse mid");
    step(5); expect_now(3'b000, "R4 short pulse ignored");

    // R4 pulse of exactly N+1 samples
    avcc_low_raw = 1'b1; step(4); avcc_low_raw = 1'b0;
    step(2); expect_now(3'b100, "R4 exact pulse accepted");
    step(3); expect_now(3'b100, "R4 fall one short");
    step(1); expect_now(3'b000, "R4 fall after N+1");

    // R1 maximum setting
    deb_sel = 8'd255; step(3);
    vdcin_drop_raw = 1'b1;
    step(257); expect_now(3'b000, "R1 max one short");
    step(1); expect_now(3'b010, "R1 max 256 samples");
    deb_sel = 8'd0; step(3);
    expect_now(3'b010, "R5 setting change keeps flag");
    vdcin_drop_raw = 1'b0; step(3);
    expect_now(3'b000, "R2 bypass clear");

    // R9 independence with setting 2
    deb_sel = 8'd2; step(3);
    vdcin_drop_raw = 1'b1;
    step(2); avcc_low_raw = 1'b1;
    step(3); expect_now(3'b010, "R9 first channel only");
    step(1); expect_now(3'b010, "R9 second still filtering");
    step(1); expect_now(3'b110, "R9 both set");

    // R5 setting change mid-count
    deb_sel = 8'd5; step(3);
    vdcin_drop_raw = 1'b0;
    step(5); deb_sel = 8'd6;
    step(7); expect_now(3'b110, "R5 restart holds flag");
    step(1); expect_now(3'b100, "R5 fall after restart");

    // R6 power-down
    avcc_det_en = 1'b0;
    step(1); expect_now(3'b000, "R6 forced low");
    step(5); expect_now(3'b000, "R6 held low");
    avcc_det_en = 1'b1;
    step(6); expect_now(3'b000, "R6 repower still filtering");
    step(1); expect_now(3'b100, "R6 repower set");
    avcc_low_raw = 1'b0; deb_sel = 8'd0; step(4);
    expect_now(3'b000, "R8 cleared");

    // R7 periodic check
    deb_sel = 8'd1; step(3);
    vdd_chk_mode = 1'b1; step(3);
    vdd_alarm_raw = 1'b1;
    step(6); expect_now(3'b000, "R7 periodic too early");
    step(5); expect_now(3'b001, "R7 periodic set");
    vdd_chk_mode = 1'b0;
    step(1); expect_now(3'b000, "R7 check off clears");
    step(4); expect_now(3'b000, "R7 check off holds");

    step(3);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule